// File: doc/BRIEF.md
# Factorial accelerator with register interrupt

This block is a memory-mapped compute engine that forms the running product 1 × 2 × … × n for a signed 32-bit operand n. Software reaches every register through a single AXI4-Lite slave port. It writes the operand, sets a start bit, and then either polls the control word or waits on a level-sensitive interrupt line. An interrupt-status register latches the completion and acceptance events. Software clears those bits by writing ones to them.

Inside the block, the multiply loop is sequential. It multiplies the product by one new factor every second clock cycle. The operand is captured at the moment a start is accepted, so software may stage the next operand while a computation is still running. The product is held to 32 bits in two's complement and wraps silently when it overflows.

Top module: `fact_engine`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0x0000000C (idle at bit 2 and ready at bit 3 set, all other bits clear). Global enable (0x04), per-source enable (0x08), status (0x0C), result (0x10) and operand (0x18) all read 0, and irq is low.
- R2: For an operand n ≥ 1, the result register at 0x10 becomes the product of the integers 1..n, truncated to 32 bits (n = 10 gives 3628800, n = 13 gives 0x7328CC00, n ≥ 34 gives 0).
- R3: For an operand that is 0 or negative as a signed value, the loop runs no iterations and the result is 1.
- R4: The loop takes two clock cycles per factor. The done status bit, and with it irq, rises exactly 2·max(n,0)+2 clock edges after the edge that accepts the start write.
- R5: Writing 1 to control bit 0 requests a start, and the bit clears itself once the engine accepts the start. Control bit 1 is done: it is set at completion and cleared by a read of the control word. Bit 2 is idle. Bit 3 is ready, which means idle with no start pending. While a computation runs, the control word reads 0.
- R6: Status bit 0 is set by completion and bit 1 by start acceptance, each only while the matching per-source enable bit (same position) is 1. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: irq equals global-enable bit 0 AND the OR over both sources of (enable bit AND status bit).
- R8: A write to the operand register during a computation does not change that computation's result. The new value is used by the next start.
- R9: Writes honour byte strobes: only the lanes whose strobe bit is set are updated. A control write whose lane-0 strobe is clear starts nothing.
- R10: Every write and read returns OKAY (0). Each channel has at most one transaction outstanding, and a pending response holds valid and data stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_axil_awaddr | input | ADDR_W | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wstrb | input | 4 | Write byte strobes |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | ADDR_W | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The loop is driven with directed operands 0, 1, 5 and a negative value. These separate the empty-loop path from a single iteration and a multi-step run, and they also pin down the exact latency of each. Random operands between -5 and 35 cross the 32-bit overflow boundary (n ≥ 13) and reach the all-zero region (n ≥ 34), which shows that the product wraps rather than saturates. An operand rewritten mid-run, and partial-strobe writes, show whether the value is captured at acceptance and whether lane updates stay separate. Toggling the enables against a set status shows the interrupt gating term by term.

// File: rtl/fact_pkg.sv
package fact_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int N_EV   = 2;

    // word index (byte offset >> 2); software depends on these
    typedef enum logic [2:0] {
        R_CTRL = 3'd0,
        R_GIE  = 3'd1,
        R_IER  = 3'd2,
        R_ISR  = 3'd3,
        R_RES  = 3'd4,
        R_OPND = 3'd6
    } reg_idx_e;

    // event positions shared by enable and status registers
    localparam int EV_DONE  = 0;
    localparam int EV_READY = 1;

    // control word bit positions
    localparam int CB_START = 0;
    localparam int CB_DONE  = 1;
    localparam int CB_IDLE  = 2;
    localparam int CB_READY = 3;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [1:0] {
        L_IDLE,
        L_RUN,
        L_FIN
    } loop_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] prod;
        logic [DATA_W-1:0] idx;
        logic [DATA_W-1:0] lim;
        logic              phase;
    } loop_t;

    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [STRB_W-1:0] strb
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < STRB_W; b++) begin
            if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/fact_axil_port.sv
module fact_axil_port
    import fact_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);

    logic              bvalid_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;

    // address and data are taken together, once the previous response is gone
    assign wr_fire   = s_awvalid & s_wvalid & ~bvalid_q;
    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign wr_addr   = s_awaddr;
    assign wr_data   = s_wdata;
    assign wr_strb   = s_wstrb;

    always_ff @(posedge clk) begin
        if (rst)           bvalid_q <= 1'b0;
        else if (wr_fire)  bvalid_q <= 1'b1;
        else if (s_bready) bvalid_q <= 1'b0;
    end

    assign s_bvalid = bvalid_q;
    assign s_bresp  = RESP_OKAY;

    assign s_arready = ~rvalid_q;
    assign rd_fire   = s_arvalid & ~rvalid_q;
    assign rd_addr   = s_araddr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_data;
        end else if (s_rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assign s_rvalid = rvalid_q;
    assign s_rdata  = rdata_q;
    assign s_rresp  = RESP_OKAY;

endmodule

// File: rtl/fact_mul_loop.sv
module fact_mul_loop
    import fact_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    output logic              idle,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    loop_state_e       st;
    loop_t             lp;
    logic [DATA_W-1:0] result_q;

    assign idle   = (st == L_IDLE);
    assign done   = (st == L_FIN);
    assign result = result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= L_IDLE;
            lp       <= '{prod: DATA_W'(1), idx: DATA_W'(1), lim: '0, phase: 1'b0};
            result_q <= '0;
        end else begin
            unique case (st)
                L_IDLE: if (start) begin
                    lp <= '{prod: DATA_W'(1), idx: DATA_W'(1), lim: operand, phase: 1'b0};
                    st <= ($signed(operand) < 1) ? L_FIN : L_RUN;
                end
                L_RUN: begin
                    lp.phase <= ~lp.phase;
                    if (lp.phase) begin
                        lp.prod <= lp.prod * lp.idx;
                        if (lp.idx == lp.lim) st <= L_FIN;
                        else                  lp.idx <= lp.idx + DATA_W'(1);
                    end
                end
                L_FIN: begin
                    result_q <= lp.prod;
                    st       <= L_IDLE;
                end
                default: st <= L_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fact_irq.sv
module fact_irq
    import fact_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            gie_wr,
    input  logic            ier_wr,
    input  logic            isr_wr,
    input  logic [N_EV-1:0] wbits,
    input  logic [N_EV-1:0] events,
    output logic            gie,
    output logic [N_EV-1:0] ier,
    output logic [N_EV-1:0] isr,
    output logic            irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gie <= 1'b0;
            ier <= '0;
        end else begin
            if (gie_wr) gie <= wbits[0];
            if (ier_wr) ier <= wbits;
        end
    end

    // an event that arrives in the same cycle as a clear wins
    for (genvar b = 0; b < N_EV; b++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)                       isr[b] <= 1'b0;
            else if (events[b] & ier[b])   isr[b] <= 1'b1;
            else if (isr_wr & wbits[b])    isr[b] <= 1'b0;
        end
    end

    assign irq = gie & |(ier & isr);

endmodule

// File: rtl/fact_engine.sv
module fact_engine
    import fact_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] s_axil_awaddr,
    input  logic              s_axil_awvalid,
    output logic              s_axil_awready,
    input  logic [31:0]       s_axil_wdata,
    input  logic [3:0]        s_axil_wstrb,
    input  logic              s_axil_wvalid,
    output logic              s_axil_wready,
    output logic [1:0]        s_axil_bresp,
    output logic              s_axil_bvalid,
    input  logic              s_axil_bready,
    input  logic [ADDR_W-1:0] s_axil_araddr,
    input  logic              s_axil_arvalid,
    output logic              s_axil_arready,
    output logic [31:0]       s_axil_rdata,
    output logic [1:0]        s_axil_rresp,
    output logic              s_axil_rvalid,
    input  logic              s_axil_rready,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic              wr_fire, rd_fire;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [STRB_W-1:0] wr_strb;
    logic [IDX_W-1:0]  wr_idx, rd_idx;

    logic              start_pend, done_flag, accept;
    logic [DATA_W-1:0] operand_q, result;
    logic              loop_idle, loop_done;
    logic              gie;
    logic [N_EV-1:0]   ier, isr, events;
    logic              wr_ctrl, wr_opnd, rd_ctrl;

    fact_axil_port #(.ADDR_W(ADDR_W)) i_port (
        .clk(clk), .rst(rst),
        .s_awaddr(s_axil_awaddr), .s_awvalid(s_axil_awvalid), .s_awready(s_axil_awready),
        .s_wdata(s_axil_wdata), .s_wstrb(s_axil_wstrb), .s_wvalid(s_axil_wvalid),
        .s_wready(s_axil_wready), .s_bresp(s_axil_bresp), .s_bvalid(s_axil_bvalid),
        .s_bready(s_axil_bready), .s_araddr(s_axil_araddr), .s_arvalid(s_axil_arvalid),
        .s_arready(s_axil_arready), .s_rdata(s_axil_rdata), .s_rresp(s_axil_rresp),
        .s_rvalid(s_axil_rvalid), .s_rready(s_axil_rready),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign wr_idx = wr_addr[ADDR_W-1:2];
    assign rd_idx = rd_addr[ADDR_W-1:2];

    assign wr_ctrl = wr_fire & (wr_idx == IDX_W'(R_CTRL));
    assign wr_opnd = wr_fire & (wr_idx == IDX_W'(R_OPND));
    assign rd_ctrl = rd_fire & (rd_idx == IDX_W'(R_CTRL));

    assign accept = start_pend & loop_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_pend <= 1'b0;
            done_flag  <= 1'b0;
            operand_q  <= '0;
        end else begin
            if (wr_ctrl & wr_strb[0] & wr_data[CB_START]) start_pend <= 1'b1;
            else if (accept)                               start_pend <= 1'b0;

            if (loop_done)    done_flag <= 1'b1;
            else if (rd_ctrl) done_flag <= 1'b0;

            if (wr_opnd) operand_q <= merge_lanes(operand_q, wr_data, wr_strb);
        end
    end

    fact_mul_loop i_loop (
        .clk(clk), .rst(rst), .start(accept), .operand(operand_q),
        .idle(loop_idle), .done(loop_done), .result(result)
    );

    assign events[EV_DONE]  = loop_done;
    assign events[EV_READY] = accept;

    fact_irq i_irq (
        .clk(clk), .rst(rst),
        .gie_wr(wr_fire & (wr_idx == IDX_W'(R_GIE)) & wr_strb[0]),
        .ier_wr(wr_fire & (wr_idx == IDX_W'(R_IER)) & wr_strb[0]),
        .isr_wr(wr_fire & (wr_idx == IDX_W'(R_ISR)) & wr_strb[0]),
        .wbits(wr_data[N_EV-1:0]), .events(events),
        .gie(gie), .ier(ier), .isr(isr), .irq(irq)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_idx)
            IDX_W'(R_CTRL): begin
                rd_data[CB_START] = start_pend;
                rd_data[CB_DONE]  = done_flag;
                rd_data[CB_IDLE]  = loop_idle;
                rd_data[CB_READY] = loop_idle & ~start_pend;
            end
            IDX_W'(R_GIE):  rd_data[0] = gie;
            IDX_W'(R_IER):  rd_data[N_EV-1:0] = ier;
            IDX_W'(R_ISR):  rd_data[N_EV-1:0] = isr;
            IDX_W'(R_RES):  rd_data = result;
            IDX_W'(R_OPND): rd_data = operand_q;
            default:        rd_data = '0;
        endcase
    end

endmodule

// File: rtl/fact_engine_chk.sv
module fact_engine_chk
    import fact_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp,
    input logic              irq,
    input logic              gie,
    input logic [N_EV-1:0]   ier,
    input logic [N_EV-1:0]   isr,
    input logic              accept,
    input logic              idle,
    input logic              done,
    input logic [DATA_W-1:0] result
);

    a_r10_bresp_okay: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> bresp == RESP_OKAY);

    a_r10_rresp_okay: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> rresp == RESP_OKAY);

    a_r10_b_hold: assert property (@(posedge clk) disable iff (rst)
        bvalid && !bready |=> bvalid);

    a_r10_r_hold: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata));

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
        !gie |-> !irq);

    a_r7_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> |(ier & isr));

    a_r6_done_latched: assert property (@(posedge clk) disable iff (rst)
        done && ier[EV_DONE] |=> isr[EV_DONE]);

    a_r6_ready_latched: assert property (@(posedge clk) disable iff (rst)
        accept && ier[EV_READY] |=> isr[EV_READY]);

    a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !idle);

    a_r8_result_only_on_done: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(result));

endmodule

bind fact_engine fact_engine_chk i_chk (
    .clk(clk), .rst(rst),
    .bvalid(s_axil_bvalid), .bready(s_axil_bready), .bresp(s_axil_bresp),
    .rvalid(s_axil_rvalid), .rready(s_axil_rready), .rdata(s_axil_rdata),
    .rresp(s_axil_rresp), .irq(irq), .gie(gie), .ier(ier), .isr(isr),
    .accept(accept), .idle(loop_idle), .done(loop_done), .result(result)
);

// File: tb/test_fact_engine.sv
module test_fact_engine;

    localparam int ADDR_W = 5;
    localparam logic [4:0] A_CTRL = 5'h00, A_GIE = 5'h04, A_IER = 5'h08,
                           A_ISR = 5'h0C, A_RES = 5'h10, A_OPND = 5'h18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, arvalid = 0;
    logic bready = 1, rready = 1;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid, irq;
    logic [1:0] bresp, rresp;
    logic [31:0] rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    fact_engine #(.ADDR_W(ADDR_W)) i_fact_engine (
        .clk(clk), .rst(rst),
        .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
        .s_axil_wdata(wdata), .s_axil_wstrb(wstrb), .s_axil_wvalid(wvalid),
        .s_axil_wready(wready), .s_axil_bresp(bresp), .s_axil_bvalid(bvalid),
        .s_axil_bready(bready), .s_axil_araddr(araddr), .s_axil_arvalid(arvalid),
        .s_axil_arready(arready), .s_axil_rdata(rdata), .s_axil_rresp(rresp),
        .s_axil_rvalid(rvalid), .s_axil_rready(rready), .irq(irq)
    );

    function automatic logic [31:0] fact_ref(input int n);
        logic [31:0] k;
        k = 32'd1;
        for (int i = 1; i <= n; i++) k = k * 32'(i);
        return k;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        check("R10 write response", {29'b0, bvalid, bresp}, 32'h4);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1;
        @(negedge clk);
        arvalid = 0;
        check("R10 read response", {29'b0, rvalid, rresp}, 32'h4);
        d = rdata;
    endtask

    task automatic wait_irq(output int cyc);
        cyc = 0;
        while (!irq && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cyc;
        int n;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 32'hC);
        rd(A_GIE, v);  check("R1 gie", v, 0);
        rd(A_IER, v);  check("R1 ier", v, 0);
        rd(A_ISR, v);  check("R1 isr", v, 0);
        rd(A_RES, v);  check("R1 result", v, 0);
        rd(A_OPND, v); check("R1 operand", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R6 nothing latched without enables; R5 done bit read-clear
        wr(A_OPND, 32'd4, 4'hF);
        wr(A_CTRL, 32'd1, 4'hF);
        idle_cycles(20);
        rd(A_ISR, v);  check("R6 no enable", v, 0);
        rd(A_CTRL, v); check("R5 done set", v, 32'hE);
        rd(A_CTRL, v); check("R5 done cleared", v, 32'hC);
        rd(A_RES, v);  check("R2 4!", v, 32'd24);

        // R6 both sources, R7 gating
        wr(A_IER, 32'd3, 4'hF);
        wr(A_OPND, 32'd3, 4'hF);
        wr(A_CTRL, 32'd1, 4'hF);
        idle_cycles(20);
        rd(A_ISR, v);  check("R6 both set", v, 32'd3);
        check("R7 gie off", {31'b0, irq}, 0);
        wr(A_GIE, 32'd1, 4'hF);
        check("R7 gie on", {31'b0, irq}, 1);
        wr(A_IER, 32'd0, 4'hF);
        check("R7 ier off", {31'b0, irq}, 0);
        wr(A_IER, 32'd3, 4'hF);
        wr(A_ISR, 32'd0, 4'hF);
        rd(A_ISR, v);  check("R6 write zero", v, 32'd3);
        wr(A_ISR, 32'd1, 4'hF);
        rd(A_ISR, v);  check("R6 clear done", v, 32'd2);
        check("R7 ready only", {31'b0, irq}, 1);
        wr(A_ISR, 32'd2, 4'hF);
        rd(A_ISR, v);  check("R6 clear ready", v, 0);
        check("R7 all clear", {31'b0, irq}, 0);
        rd(A_CTRL, v);

        // R4 latency, R2/R3 values
        wr(A_IER, 32'd1, 4'hF);
        foreach (v[k]) if (k < 4) begin
            n = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : -3;
            wr(A_OPND, 32'(n), 4'hF);
            wr(A_CTRL, 32'd1, 4'hF);
            wait_irq(cyc);
            check("R4 latency", 32'(cyc), 32'(2 * (n > 0 ? n : 0) + 2));
            rd(A_RES, v);
            check(n > 0 ? "R2 product" : "R3 empty loop", v, fact_ref(n));
            wr(A_ISR, 32'd1, 4'hF);
            rd(A_CTRL, v);
        end

        // R5 busy view, R8 operand isolation
        wr(A_OPND, 32'd12, 4'hF);
        wr(A_CTRL, 32'd1, 4'hF);
        @(negedge clk);
        rd(A_CTRL, v); check("R5 running", v, 0);
        wr(A_OPND, 32'd2, 4'hF);
        wait_irq(cyc);
        rd(A_RES, v);  check("R8 old operand", v, 32'd479001600);
        wr(A_ISR, 32'd1, 4'hF);
        rd(A_CTRL, v); check("R5 after run", v, 32'hE);
        wr(A_CTRL, 32'd1, 4'hF);
        wait_irq(cyc);
        rd(A_RES, v);  check("R8 new operand", v, 32'd2);
        wr(A_ISR, 32'd1, 4'hF);
        rd(A_CTRL, v);

        // R9 byte strobes
        wr(A_OPND, 32'h12345678, 4'hF);
        wr(A_OPND, 32'h000000AB, 4'h1);
        wr(A_OPND, 32'hCD000000, 4'h8);
        rd(A_OPND, v); check("R9 lanes", v, 32'hCD3456AB);
        wr(A_CTRL, 32'd1, 4'h0);
        idle_cycles(10);
        rd(A_CTRL, v); check("R9 no start", v, 32'hC);
        check("R9 no irq", {31'b0, irq}, 0);

        // random operands across the wrap boundary
        for (int t = 0; t < 30; t++) begin
            n = int'($urandom_range(40, 0)) - 5;
            wr(A_OPND, 32'(n), 4'hF);
            wr(A_CTRL, 32'd1, 4'hF);
            wait_irq(cyc);
            rd(A_RES, v);
            check(n > 0 ? "R2 random" : "R3 random", v, fact_ref(n));
            wr(A_ISR, 32'd1, 4'hF);
            rd(A_CTRL, v); check("R5 random done", v, 32'hE);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule